// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address and a set of access rights for one of four privilege modes, where mode 0 is the most privileged. It first rejects addresses that are not properly sign-extended. It then takes one of two paths. A direct-mapped window that only mode 0 may use is translated without touching memory. Any other address is resolved by reading one table entry at each of three levels, starting from a table base address supplied on an input port.

Each request is accepted in a single cycle when the walker is idle. Table reads leave through a valid/ready read port that has at most one read outstanding; the data comes back on a separate valid strobe. The outcome is a one-cycle response pulse. It carries either a success flag with the physical address and the rights, or a fault code. The requester, typically a TLB refill path, holds no state of its own inside the walker.

Top module: `pgwalk_top`

## Requirements
- R1: An address whose bits 63:43 are not all equal is answered with fault code 1 (access violation) in the cycle after acceptance, and no table read is issued.
- R2: An address with bit 63 set and bits 42:41 equal to binary 10 is a direct-mapped window access. In mode 0 it succeeds with physical bits 39:0 copied from the address, physical bit 43 equal to address bit 40, all other physical bits zero and rights 3'b111. In any other mode it gives fault code 1. Neither case reads memory.
- R3: The table entry for a level is read at table_base + index*8. The level-1, level-2 and level-3 indices are address bits 42:33, 32:23 and 22:13. The level-1 base is the base input, and each later base is entry bits 63:32 shifted left by 13.
- R4: An entry with bit 0 clear at any level ends the walk with fault code 2 (translation not valid).
- R5: A level-1 or level-2 entry that is valid but has bit 8 clear ends the walk with fault code 1.
- R6: At level 3, read and execute rights come from entry bit 8+mode and the write right from entry bit 12+mode. The needed-access and rights encodings are bit 0 read, bit 1 write and bit 2 execute. A nonzero need that shares no bit with these rights gives fault code 1.
- R7: Entry bit 1 then removes read, bit 2 removes write and bit 3 removes execute. If a nonzero need then shares no bit with the remaining rights, the fault is 5 when execute is needed, else 4 when write is needed, else 3.
- R8: On success rsp_ok is 1 and rsp_fault is 0. After a walk, rsp_paddr is (entry bits 63:32 shifted left by 13) OR address bits 12:0, and rsp_prot holds the remaining rights. On any fault, rsp_ok, rsp_paddr and rsp_prot are all zero.
- R9: A read request holds mem_rd_valid and a stable mem_rd_addr until mem_rd_ready, and no new read is issued until the data strobe for the previous one has arrived.
- R10: req_ready is high only when idle. rsp_valid is high for exactly one cycle. The latency from acceptance is one cycle plus, for each level read, two cycles plus any cycles of ready stall and data delay.
- R11: A need of zero that passes the level-3 valid check succeeds, even when the entry grants no rights, and returns the remaining rights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ptbase | input | 64 | Physical base of the level-1 table |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 64 | Virtual address |
| req_need | input | 3 | Needed access: bit0 read, bit1 write, bit2 execute |
| req_mode | input | 2 | Privilege mode index, 0 most privileged |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 64 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | Response pulse |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_fault | output | 3 | Fault code: 0 none, 1 access violation, 2 not valid, 3 read, 4 write, 5 execute |
| rsp_paddr | output | 64 | Physical address |
| rsp_prot | output | 3 | Remaining rights: bit0 read, bit1 write, bit2 execute |

## Verification
A wrong level state or a stale table base shows at the memory port at once: the next mem_rd_addr breaks the base-plus-index rule, and it is compared against the bench's own walk on the cycle it appears. A lost or duplicated issue flag either stalls the walk or repeats a read. Either one moves the response pulse off the cycle the bench predicts from the stall and delay settings, so the mismatch is reported within that same cycle. Wrong rights or fault selection show only at the response pulse, where every field is compared. Stalls and data delays on the read port are varied so that holding behaviour is exercised as well.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_ACV  = 3'd1,
        FLT_TNV  = 3'd2,
        FLT_FOR  = 3'd3,
        FLT_FOW  = 3'd4,
        FLT_FOE  = 3'd5
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_L1   = 3'd1,
        ST_L2   = 3'd2,
        ST_L3   = 3'd3,
        ST_DONE = 3'd4
    } state_e;

    localparam int ENT_VALID_BIT = 0;
    localparam int ENT_NO_RD_BIT = 1;
    localparam int ENT_NO_EX_BIT = 3;
    localparam int ENT_RD_BASE   = 8;
    localparam int ENT_WR_BASE   = 12;
    localparam int ENT_LINK_LO   = 32;

endpackage

// File: rtl/pgwalk_precheck.sv
module pgwalk_precheck #(
    parameter int ADDR_W    = 64,
    parameter int IMPL_BITS = 43
) (
    input  logic [ADDR_W-1:0] va,
    output logic              canon,
    output logic              window_hit,
    output logic [ADDR_W-1:0] window_pa
);
    localparam int LOW_W   = IMPL_BITS - 3;
    localparam int UPPER_W = ADDR_W - IMPL_BITS;

    logic [UPPER_W-1:0] upper;

    always_comb begin
        upper      = va[ADDR_W-1:IMPL_BITS];
        canon      = (&upper) | ~(|upper);
        window_hit = va[ADDR_W-1] && (va[IMPL_BITS-1:IMPL_BITS-2] == 2'b10);
        window_pa  = '0;
        window_pa[LOW_W-1:0] = va[LOW_W-1:0];
        window_pa[IMPL_BITS] = va[LOW_W];
    end

endmodule

// File: rtl/pgwalk_leaf_eval.sv
module pgwalk_leaf_eval
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int MODE_W = 2
) (
    input  logic [ADDR_W-1:0] ent,
    input  logic [2:0]        need,
    input  logic [MODE_W-1:0] mode,
    output logic              pass,
    output fault_e            code,
    output logic [2:0]        prot
);
    logic       rd_en;
    logic       wr_en;
    logic [2:0] granted;
    logic [2:0] masked;

    always_comb begin
        rd_en   = ent[ENT_RD_BASE + int'(mode)];
        wr_en   = ent[ENT_WR_BASE + int'(mode)];
        granted = {rd_en, wr_en, rd_en};
        masked  = granted & ~ent[ENT_NO_EX_BIT:ENT_NO_RD_BIT];
        pass    = 1'b0;
        code    = FLT_ACV;
        prot    = '0;
        if ((need != 3'b000) && ((granted & need) == 3'b000)) begin
            code = FLT_ACV;
        end else if ((need != 3'b000) && ((masked & need) == 3'b000)) begin
            if (need[2])      code = FLT_FOE;
            else if (need[1]) code = FLT_FOW;
            else              code = FLT_FOR;
        end else begin
            pass = 1'b1;
            code = FLT_NONE;
            prot = masked;
        end
    end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int IMPL_BITS = 43,
    parameter int PAGE_BITS = 13,
    parameter int IDX_W     = 10,
    parameter int MODE_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ptbase,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [2:0]        req_need,
    input  logic [MODE_W-1:0] req_mode,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [2:0]        rsp_fault,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [2:0]        rsp_prot
);
    localparam int LEVELS    = 3;
    localparam int ENT_BYTES = 3;
    localparam int LINK_W    = ADDR_W - ENT_LINK_LO;

    typedef struct packed {
        state_e             st;
        logic               issued;
        logic [ADDR_W-1:0]  base;
        logic [ADDR_W-1:0]  va;
        logic [2:0]         need;
        logic [MODE_W-1:0]  mode;
        logic               ok;
        fault_e             fault;
        logic [ADDR_W-1:0]  paddr;
        logic [2:0]         prot;
    } walk_t;

    walk_t r_q, r_d;

    logic              canon;
    logic              window_hit;
    logic [ADDR_W-1:0] window_pa;
    logic              leaf_pass;
    fault_e            leaf_code;
    logic [2:0]        leaf_prot;
    logic [ADDR_W-1:0] link_addr;
    logic [IDX_W-1:0]  lvl_idx [LEVELS];
    logic [IDX_W-1:0]  cur_idx;

    pgwalk_precheck #(.ADDR_W(ADDR_W), .IMPL_BITS(IMPL_BITS)) u_pre (
        .va        (req_vaddr),
        .canon     (canon),
        .window_hit(window_hit),
        .window_pa (window_pa)
    );

    pgwalk_leaf_eval #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_leaf (
        .ent (mem_rsp_data),
        .need(r_q.need),
        .mode(r_q.mode),
        .pass(leaf_pass),
        .code(leaf_code),
        .prot(leaf_prot)
    );

    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign lvl_idx[g] = r_q.va[PAGE_BITS + (LEVELS-1-g)*IDX_W +: IDX_W];
    end

    always_comb begin
        case (r_q.st)
            ST_L2:   cur_idx = lvl_idx[1];
            ST_L3:   cur_idx = lvl_idx[2];
            default: cur_idx = lvl_idx[0];
        endcase
        link_addr = {{(ADDR_W-LINK_W){1'b0}}, mem_rsp_data[ADDR_W-1:ENT_LINK_LO]} << PAGE_BITS;
    end

    assign mem_rd_addr = r_q.base + ({{(ADDR_W-IDX_W){1'b0}}, cur_idx} << ENT_BYTES);

    always_comb begin
        r_d          = r_q;
        req_ready    = 1'b0;
        mem_rd_valid = 1'b0;
        rsp_valid    = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    r_d.va     = req_vaddr;
                    r_d.need   = req_need;
                    r_d.mode   = req_mode;
                    r_d.issued = 1'b0;
                    r_d.ok     = 1'b0;
                    r_d.fault  = FLT_ACV;
                    r_d.paddr  = '0;
                    r_d.prot   = '0;
                    if (!canon) begin
                        r_d.st = ST_DONE;
                    end else if (window_hit) begin
                        r_d.st = ST_DONE;
                        if (req_mode == '0) begin
                            r_d.ok    = 1'b1;
                            r_d.fault = FLT_NONE;
                            r_d.paddr = window_pa;
                            r_d.prot  = 3'b111;
                        end
                    end else begin
                        r_d.base = ptbase;
                        r_d.st   = ST_L1;
                    end
                end
            end
            ST_L1, ST_L2, ST_L3: begin
                mem_rd_valid = !r_q.issued;
                if (!r_q.issued) begin
                    if (mem_rd_ready) r_d.issued = 1'b1;
                end else if (mem_rsp_valid) begin
                    r_d.issued = 1'b0;
                    if (!mem_rsp_data[ENT_VALID_BIT]) begin
                        r_d.fault = FLT_TNV;
                        r_d.st    = ST_DONE;
                    end else if (r_q.st != ST_L3) begin
                        if (!mem_rsp_data[ENT_RD_BASE]) begin
                            r_d.fault = FLT_ACV;
                            r_d.st    = ST_DONE;
                        end else begin
                            r_d.base = link_addr;
                            r_d.st   = (r_q.st == ST_L1) ? ST_L2 : ST_L3;
                        end
                    end else begin
                        r_d.st    = ST_DONE;
                        r_d.fault = leaf_code;
                        if (leaf_pass) begin
                            r_d.ok    = 1'b1;
                            r_d.prot  = leaf_prot;
                            r_d.paddr = link_addr |
                                {{(ADDR_W-PAGE_BITS){1'b0}}, r_q.va[PAGE_BITS-1:0]};
                        end
                    end
                end
            end
            ST_DONE: begin
                rsp_valid = 1'b1;
                r_d.st    = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, issued: 1'b0, base: '0, va: '0, need: '0,
                     mode: '0, ok: 1'b0, fault: FLT_NONE, paddr: '0, prot: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_ok    = r_q.ok;
    assign rsp_fault = r_q.fault;
    assign rsp_paddr = r_q.paddr;
    assign rsp_prot  = r_q.prot;

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    // R9
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && mem_rd_ready |=> !mem_rd_valid);

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready);

    // R8
    flt_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ok |-> rsp_paddr == '0 && rsp_prot == '0 && rsp_fault != 3'd0);

    // R1
    noncanon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !canon |=> rsp_valid && rsp_fault == 3'd1 && !mem_rd_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_valid && !rsp_valid);

endmodule

// File: tb/sim_pgwalk_top.sv
module sim_pgwalk_top;
    localparam logic [63:0] PTB = 64'h0000_0000_0040_0000;
    localparam logic [31:0] V = 32'h1, NR = 32'h2, NW = 32'h4, NX = 32'h8;
    localparam logic [31:0] KR = 32'h100, UR = 32'h800, KW = 32'h1000, UW = 32'h8000;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0;
    logic [63:0] req_vaddr = '0;
    logic [2:0]  req_need = '0;
    logic [1:0]  req_mode = '0;
    logic        mem_rd_ready = 0;
    logic        mem_rsp_valid = 0;
    logic [63:0] mem_rsp_data = '0;
    logic        req_ready, mem_rd_valid, rsp_valid, rsp_ok;
    logic [63:0] mem_rd_addr, rsp_paddr;
    logic [2:0]  rsp_fault, rsp_prot;

    int errors = 0;
    int checks = 0;
    int stall_n = 0;
    int delay_n = 0;
    logic [63:0] mem [logic [63:0]];
    logic [63:0] exp_q [$];

    always #5 clk = ~clk;

    pgwalk_top u0 (
        .clk(clk), .rst_n(rst_n), .ptbase(PTB),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_need(req_need), .req_mode(req_mode),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .rsp_prot(rsp_prot)
    );

    task automatic chk(input bit good, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] rd_mem(input logic [63:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'h0;
    endfunction

    // memory model: ready after stall_n cycles, data delay_n cycles after the handshake
    int   scnt = 0;
    int   wcnt = 0;
    bit   armed = 0;
    logic [63:0] held_addr = '0;
    always @(negedge clk) begin
        mem_rsp_valid = 0;
        if (armed) begin
            mem_rd_ready = 0;
            if (mem_rd_valid) chk(0, "R9 second read while outstanding", mem_rd_addr, 64'h0);
            if (wcnt == 0) begin
                mem_rsp_valid = 1;
                mem_rsp_data  = rd_mem(held_addr);
                armed = 0;
            end else wcnt--;
        end else if (mem_rd_valid) begin
            if (exp_q.size() == 0) chk(0, "R3 unexpected read", mem_rd_addr, 64'h0);
            else chk(mem_rd_addr == exp_q[0], "R3/R9 read address", mem_rd_addr, exp_q[0]);
            if (scnt >= stall_n) begin
                mem_rd_ready = 1;
                armed = 1;
                wcnt = delay_n;
                scnt = 0;
                held_addr = mem_rd_addr;
                if (exp_q.size() != 0) void'(exp_q.pop_front());
            end else begin
                mem_rd_ready = 0;
                scnt++;
            end
        end else begin
            mem_rd_ready = 0;
        end
    end

    function automatic void ref_walk(input logic [63:0] va, input logic [2:0] need, input int mode,
                                     output logic ok, output logic [2:0] flt, output logic [63:0] pa,
                                     output logic [2:0] pr, output int lv);
        logic [63:0] tb;
        logic [63:0] ent;
        logic [63:0] a;
        logic rd, wr, ex;
        tb = PTB; ent = '0;
        ok = 0; flt = 3'd1; pa = '0; pr = '0; lv = 0;
        if (!(va[63:43] == '1 || va[63:43] == '0)) return;
        if (va[63] && va[42:41] == 2'b10) begin
            if (mode != 0) return;
            ok = 1; flt = 0; pr = 3'b111;
            pa = va & 64'h0000_00FF_FFFF_FFFF;
            if (va[40]) pa = pa + 64'h0000_0800_0000_0000;
            return;
        end
        for (int l = 0; l < 3; l++) begin
            a = tb + (((va >> (13 + 10 * (2 - l))) & 64'h3FF) * 8);
            exp_q.push_back(a);
            lv++;
            ent = rd_mem(a);
            if (!ent[0]) begin flt = 3'd2; return; end
            if (l < 2) begin
                if (!ent[8]) begin flt = 3'd1; return; end
                tb = (ent >> 32) << 13;
            end
        end
        rd = ent[8 + mode]; wr = ent[12 + mode]; ex = rd;
        if (need != 0 && ({ex, wr, rd} & need) == 0) begin flt = 3'd1; return; end
        if (ent[1]) rd = 0;
        if (ent[2]) wr = 0;
        if (ent[3]) ex = 0;
        if (need != 0 && ({ex, wr, rd} & need) == 0) begin
            flt = need[2] ? 3'd5 : (need[1] ? 3'd4 : 3'd3);
            return;
        end
        ok = 1; flt = 0; pr = {ex, wr, rd};
        pa = ((ent >> 32) << 13) | (va & 64'h1FFF);
    endfunction

    function automatic logic [63:0] mkva(input bit neg, input int i1, input int i2, input int i3, input int off);
        logic [63:0] v;
        v = (64'(i1 & 32'h3FF) << 33) | (64'(i2 & 32'h3FF) << 23) | (64'(i3 & 32'h3FF) << 13) | 64'(off & 32'h1FFF);
        if (neg) v = v | 64'hFFFF_F800_0000_0000;
        return v;
    endfunction

    task automatic map3(input logic [63:0] va, input logic [31:0] f1, input logic [31:0] f2,
                        input logic [31:0] f3, input logic [31:0] t2, input logic [31:0] t3,
                        input logic [31:0] pg);
        logic [63:0] a;
        a = PTB + 64'(va[42:33]) * 8;                 mem[a] = {t2, f1};
        a = (64'(t2) << 13) + 64'(va[32:23]) * 8;     mem[a] = {t3, f2};
        a = (64'(t3) << 13) + 64'(va[22:13]) * 8;     mem[a] = {pg, f3};
    endtask

    task automatic run(input logic [63:0] va, input logic [2:0] need, input logic [1:0] mode,
                       input int s, input int d, input string tag);
        logic e_ok; logic [2:0] e_flt; logic [63:0] e_pa; logic [2:0] e_pr; int lv; int lat;
        exp_q.delete();
        ref_walk(va, need, int'(mode), e_ok, e_flt, e_pa, e_pr, lv);
        lat = lv * (2 + s + d);
        stall_n = s; delay_n = d;
        @(negedge clk);
        chk(req_ready == 1, {tag, " R10 ready before request"}, 64'(req_ready), 64'h1);
        req_valid = 1; req_vaddr = va; req_need = need; req_mode = mode;
        @(negedge clk);
        req_valid = 0;
        for (int c = 0; c <= lat; c++) begin
            chk(rsp_valid == (c == lat), {tag, " R10 response timing"}, 64'(rsp_valid), 64'(c == lat));
            chk(req_ready == 0, {tag, " R10 busy"}, 64'(req_ready), 64'h0);
            if (c == lat) begin
                chk(rsp_ok == e_ok, {tag, " R8 ok"}, 64'(rsp_ok), 64'(e_ok));
                chk(rsp_fault == e_flt, {tag, " fault code"}, 64'(rsp_fault), 64'(e_flt));
                chk(rsp_paddr == e_pa, {tag, " R8 paddr"}, rsp_paddr, e_pa);
                chk(rsp_prot == e_pr, {tag, " R8 prot"}, 64'(rsp_prot), 64'(e_pr));
            end
            if (c < lat) @(negedge clk);
        end
        @(negedge clk);
        chk(rsp_valid == 0 && req_ready == 1, {tag, " R10 back to idle"}, 64'({rsp_valid, req_ready}), 64'h1);
        chk(exp_q.size() == 0, {tag, " R3 read count"}, 64'(exp_q.size()), 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R10 watchdog act=hung exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] va;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(req_ready == 1 && rsp_valid == 0 && mem_rd_valid == 0, "R10 reset outputs",
            64'({req_ready, rsp_valid, mem_rd_valid}), 64'h4);
        rst_n = 1;

        // R1 non-canonical addresses
        run(64'h0000_0800_0000_0000, 3'b001, 2'd0, 0, 0, "R1 pos");
        run(64'hFFF7_F000_0000_1000, 3'b001, 2'd0, 0, 0, "R1 neg");
        // R2 window
        run(64'hFFFF_FD12_3456_789A, 3'b010, 2'd0, 0, 0, "R2 kernel bit40");
        run(64'hFFFF_FC00_0000_0044, 3'b100, 2'd0, 0, 0, "R2 kernel");
        run(64'hFFFF_FD12_3456_789A, 3'b001, 2'd3, 0, 0, "R2 user");

        // R3 R8 full walk, kernel read
        va = mkva(0, 3, 5, 7, 16'h0ABC);
        map3(va, V | KR, V | KR, V | KR | KW, 32'h300, 32'h301, 32'h0012_3456);
        run(va, 3'b001, 2'd0, 0, 0, "R3 walk");
        run(va, 3'b010, 2'd0, 2, 3, "R9 stalled walk");
        // R3 negative non-window address
        va = mkva(1, 10'h3C5, 9, 11, 16'h0004);
        map3(va, V | KR, V | KR, V | UR | UW, 32'h310, 32'h311, 32'h0000_0777);
        run(va, 3'b011, 2'd3, 1, 0, "R3 neg user rw");
        // R4 invalid entries at each level
        run(mkva(0, 20, 0, 0, 0), 3'b001, 2'd0, 0, 1, "R4 L1");
        va = mkva(0, 21, 2, 3, 0);
        map3(va, V | KR, KR, V | KR, 32'h320, 32'h321, 32'h1);
        run(va, 3'b001, 2'd0, 0, 0, "R4 L2");
        va = mkva(0, 22, 2, 3, 0);
        map3(va, V | KR, V | KR, KR | KW, 32'h330, 32'h331, 32'h1);
        run(va, 3'b001, 2'd0, 0, 0, "R4 L3");
        // R5 missing read enable at upper levels
        va = mkva(0, 23, 4, 4, 0);
        map3(va, V, V | KR, V | KR, 32'h340, 32'h341, 32'h1);
        run(va, 3'b001, 2'd0, 0, 0, "R5 L1");
        va = mkva(0, 24, 4, 4, 0);
        map3(va, V | KR, V, V | KR, 32'h350, 32'h351, 32'h1);
        run(va, 3'b001, 2'd0, 0, 0, "R5 L2");
        // R6 mode-shifted permissions
        va = mkva(0, 25, 6, 6, 12);
        map3(va, V | KR, V | KR, V | KR | KW, 32'h360, 32'h361, 32'h2222);
        run(va, 3'b001, 2'd3, 0, 0, "R6 user no rights");
        va = mkva(0, 26, 6, 6, 12);
        map3(va, V | KR, V | KR, V | UR, 32'h370, 32'h371, 32'h2223);
        run(va, 3'b010, 2'd3, 0, 0, "R6 user write denied");
        run(va, 3'b100, 2'd3, 0, 0, "R6 user exec via read");
        // R7 fault-on bits and priority
        va = mkva(0, 27, 7, 7, 0);
        map3(va, V | KR, V | KR, V | KR | KW | NR, 32'h380, 32'h381, 32'h3000);
        run(va, 3'b001, 2'd0, 0, 0, "R7 fault on read");
        run(va, 3'b011, 2'd0, 0, 0, "R7 read masked write ok");
        va = mkva(0, 28, 7, 7, 0);
        map3(va, V | KR, V | KR, V | KR | KW | NW | NX, 32'h390, 32'h391, 32'h3001);
        run(va, 3'b110, 2'd0, 0, 0, "R7 exec beats write");
        va = mkva(0, 29, 7, 7, 0);
        map3(va, V | KR, V | KR, V | KR | KW | NR | NW, 32'h3A0, 32'h3A1, 32'h3002);
        run(va, 3'b011, 2'd0, 0, 0, "R7 write beats read");
        // R11 zero need
        va = mkva(0, 30, 8, 8, 0);
        map3(va, V | KR, V | KR, V, 32'h3B0, 32'h3B1, 32'h3003);
        run(va, 3'b000, 2'd0, 0, 2, "R11 zero need");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule